// File: doc/BRIEF.md
# Converter Bus Control Front End

This block is the digital side of a memory-mapped 12-bit successive-approximation converter. A host processor drives three inputs: an active-low select, an active-low read strobe and a byte-select line. When all three are low together, the block sees a conversion request. It raises a busy flag on the request's rising edge and runs a clock-cycle timer that stands in for the analog conversion. When the timer ends, it captures the value on a result-source port.

The same select and read strobes also open the output bus. A word host reads all twelve result bits in place. An 8-bit host sets the byte-select line and receives the top four result bits twice, with the four bits between them forced to zero. The tri-state bus is modelled as a data vector plus a drive-enable output. The data vector is zero whenever the enable is low.

All three strobes are asynchronous to the block clock and pass through a two-flop synchronizer first. The conversion and acquisition times are given in nanoseconds and converted to cycle counts. The synchronizer latency is subtracted from the conversion count so that the whole interval, from strobe to result, stays inside the converter's maximum conversion time.

Top module: `adc_busctl`

## Requirements
- R1: A conversion request exists only while cs_n, rd_n and hben are all 0. A select and read with hben at 1 never starts a conversion.
- R2: A conversion starts only on the rising edge of the request. Holding the strobes low after that start begins no further conversion.
- R3: busy rises on the third rising clock edge after the edge where the request is first sampled. It stays 1 for exactly CONV_CYCLES cycles, which is 672 cycles with the default parameters.
- R4: A request edge that arrives while busy is 1 is ignored. It neither extends nor restarts the conversion.
- R5: During the ACQ_CYCLES cycles after busy falls (150 with the default parameters), a request edge is ignored.
- R6: result_in is captured on the cycle in which busy falls. That value is then presented until the next conversion completes.
- R7: data_oe is 1 two cycles after cs_n and rd_n are both sampled at 0, counting from the sampling edge plus one register. data_oe is 0 otherwise. data_out is all zeros whenever data_oe is 0.
- R8: While enabled with hben sampled at 0, data_out[11:0] equals the held result bits [11:0].
- R9: While enabled with hben sampled at 1, data_out[11:8] and data_out[3:0] both carry result bits [11:8], and data_out[7:4] is 0.
- R10: After reset, busy, data_oe, data_out and the held result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| hben | input | 1 | Byte-select: 1 selects the high-byte layout |
| result_in | input | 12 | Conversion value from the bit-decision logic |
| busy | output | 1 | Conversion in progress |
| data_out | output | 12 | Result bus value, zero when not driven |
| data_oe | output | 1 | Bus drive enable (tri-state control) |

## Verification
Every result here has a fixed latency counted from the clock edge at which the bench's negedge-driven strobes are first sampled. busy rises on the third edge after that. data_oe and data_out follow the sampled strobes on the third edge as well and use the result held before that edge. The captured result changes on the same edge where busy falls. A behavioural model in the bench keeps three-deep histories of the sampled inputs, plus countdowns for the conversion and acquisition windows. It updates on each rising edge, and all three outputs are compared with it on every falling edge, so each output is checked in the exact cycle it is due. A count of busy rising edges, checked against the number of starts the stimulus plan allows, confirms that ignored and held requests started nothing.

// File: rtl/adc_busctl_pkg.sv
package adc_busctl_pkg;

  localparam int RES_W = 12;
  localparam int NIB_W = RES_W / 3;

  // strobe bundle order used by the synchronizer
  typedef struct packed {
    logic hben;
    logic rd_n;
    logic cs_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{hben: 1'b0, rd_n: 1'b1, cs_n: 1'b1};

  // byte-host layout: top nibble, zero nibble, top nibble again
  function automatic logic [RES_W-1:0] high_byte_view(input logic [RES_W-1:0] r);
    return {r[RES_W-1 -: NIB_W], {NIB_W{1'b0}}, r[RES_W-1 -: NIB_W]};
  endfunction

endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 672,
  parameter int ACQ_CYCLES  = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic busy,
  output logic done
);

  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam int AW = $clog2(ACQ_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_CYCLES - 1);
  localparam logic [AW-1:0] ACQ_LOAD = AW'(ACQ_CYCLES);

  logic          req_d;
  logic [CW-1:0] cnt;
  logic [AW-1:0] acq;
  logic          req_rise;
  logic          accept;

  assign req_rise = req & ~req_d;
  assign accept   = req_rise & ~busy & (acq == '0);
  assign done     = busy & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
      acq   <= '0;
    end else begin
      req_d <= req;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          acq  <= ACQ_LOAD;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        if (acq != '0) acq <= acq - 1'b1;
        if (accept) begin
          busy <= 1'b1;
          cnt  <= CNT_LOAD;
        end
      end
    end
  end

  assert_accept_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  assert_done_clears_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  assert_no_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && cnt == $past(cnt) - 1'b1));

  assert_acq_blocks_start_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && acq != '0) |=> !busy);

endmodule

// File: rtl/adc_bus_out.sv
module adc_bus_out
  import adc_busctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hb,
  input  logic [RES_W-1:0] res,
  output logic [RES_W-1:0] data_out,
  output logic             data_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe <= en;
      if (!en)     data_out <= '0;
      else if (hb) data_out <= high_byte_view(res);
      else         data_out <= res;
    end
  end

  assert_idle_bus_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));

  assert_mid_nibble_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (en && hb) |=> (data_out[2*NIB_W-1:NIB_W] == '0));

  assert_word_passthru_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !hb) |=> (data_out == $past(res)));

endmodule

// File: rtl/adc_busctl.sv
module adc_busctl
  import adc_busctl_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int CONV_MAX_NS   = 2700,
  parameter int ACQ_MIN_NS    = 600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             hben,
  input  logic [RES_W-1:0] result_in,
  output logic             busy,
  output logic [RES_W-1:0] data_out,
  output logic             data_oe
);

  // synchronizer plus edge register eat into the conversion budget
  localparam int CONV_CYCLES = (CONV_MAX_NS * 1000) / CLK_PERIOD_PS - (SYNC_STAGES + 1);
  localparam int ACQ_CYCLES  = (ACQ_MIN_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

  strobe_t raw_s, syn_s;
  logic    req_lvl, rd_lvl, conv_done;
  logic [RES_W-1:0] res_q;

  assign raw_s = '{hben: hben, rd_n: rd_n, cs_n: cs_n};

  adc_strobe_sync #(
    .W      ($bits(strobe_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(STROBE_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_s),
    .q  (syn_s)
  );

  assign rd_lvl  = ~syn_s.cs_n & ~syn_s.rd_n;
  assign req_lvl = rd_lvl & ~syn_s.hben;

  adc_conv_timer #(
    .CONV_CYCLES(CONV_CYCLES),
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .req (req_lvl),
    .busy(busy),
    .done(conv_done)
  );

  always_ff @(posedge clk) begin
    if (rst)            res_q <= '0;
    else if (conv_done) res_q <= result_in;
  end

  adc_bus_out u_out (
    .clk     (clk),
    .rst     (rst),
    .en      (rd_lvl),
    .hb      (syn_s.hben),
    .res     (res_q),
    .data_out(data_out),
    .data_oe (data_oe)
  );

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(res_q));

  assert_capture_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> (res_q == $past(result_in)));

endmodule

// File: tb/adc_busctl_tb_top.sv
module adc_busctl_tb_top;

  localparam int CONV = 2700 * 1000 / 4000 - 3;  // 672
  localparam int ACQ  = 600 * 1000 / 4000;       // 150
  localparam int EXP_STARTS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, hben = 1'b0;
  logic [11:0] result_in = 12'h000;
  logic busy, data_oe;
  logic [11:0] data_out;

  always #2 clk = ~clk;

  adc_busctl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
    .result_in(result_in), .busy(busy), .data_out(data_out), .data_oe(data_oe)
  );

  int checks = 0, errors = 0;
  string cur_tag = "R10";
  bit done_flag = 0;

  // behavioural reference: input history [1..3] edges back
  int h_cs[4], h_rd[4], h_hb[4];
  int m_busy, m_elapsed, m_acq, m_res, m_oe, m_data, m_hb;
  int dut_rises = 0;
  logic busy_prev = 0;

  initial begin
    for (int i = 0; i < 4; i++) begin h_cs[i] = 1; h_rd[i] = 1; h_hb[i] = 0; end
    m_busy = 0; m_elapsed = 0; m_acq = 0; m_res = 0; m_oe = 0; m_data = 0; m_hb = 0;
  end

  function automatic int req_of(int c, int r, int h);
    return (c == 0 && r == 0 && h == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin h_cs[i] = 1; h_rd[i] = 1; h_hb[i] = 0; end
      m_busy = 0; m_elapsed = 0; m_acq = 0; m_res = 0; m_oe = 0; m_data = 0; m_hb = 0;
    end else begin
      int start_ok;
      start_ok = (req_of(h_cs[2], h_rd[2], h_hb[2]) == 1 &&
                  req_of(h_cs[3], h_rd[3], h_hb[3]) == 0 &&
                  m_busy == 0 && m_acq == 0) ? 1 : 0;
      m_oe = (h_cs[2] == 0 && h_rd[2] == 0) ? 1 : 0;
      m_hb = h_hb[2];
      if (m_oe == 0) m_data = 0;
      else if (m_hb != 0) m_data = ((m_res >> 8) << 8) | (m_res >> 8);
      else m_data = m_res;
      if (m_busy != 0) begin
        m_elapsed++;
        if (m_elapsed == CONV) begin m_busy = 0; m_res = int'(result_in); m_acq = ACQ; end
      end else if (m_acq > 0) m_acq--;
      if (start_ok != 0) begin m_busy = 1; m_elapsed = 0; end
      h_cs[3] = h_cs[2]; h_rd[3] = h_rd[2]; h_hb[3] = h_hb[2];
      h_cs[2] = h_cs[1]; h_rd[2] = h_rd[1]; h_hb[2] = h_hb[1];
      h_cs[1] = int'(cs_n); h_rd[1] = int'(rd_n); h_hb[1] = int'(hben);
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      check(cur_tag, "busy", int'(busy), m_busy);
      check("R7", "data_oe", int'(data_oe), m_oe);
      check((cur_tag == "R6") ? "R6" : (m_hb != 0 ? "R9" : "R8"), "data_out",
            int'(data_out), m_data);
      if (busy && !busy_prev) dut_rises++;
      busy_prev = busy;
    end
  end

  task automatic strobe(input logic hb, input int n);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; hben = hb;
    repeat (n) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy !== 1'b0; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10", "reset busy", int'(busy), 0);
    check("R10", "reset oe", int'(data_oe), 0);
    check("R10", "reset data", int'(data_out), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 / R3: word strobe starts a conversion
    cur_tag = "R3";
    result_in = 12'hA5C;
    strobe(1'b0, 5);
    wait_idle();
    repeat (ACQ + 20) @(negedge clk);

    // R1: byte-select read never starts; shows R9 layout of A5C
    cur_tag = "R1";
    strobe(1'b1, 8);
    repeat (20) @(negedge clk);
    check("R1", "no start with hben high", int'(busy), 0);

    // R2: strobes held low across a whole conversion start only once
    cur_tag = "R2";
    result_in = 12'h3C7;
    strobe(1'b0, CONV + 300);
    wait_idle();
    repeat (ACQ + 20) @(negedge clk);

    // R4: second request while busy is ignored
    cur_tag = "R4";
    result_in = 12'hF19;
    strobe(1'b0, 3);
    repeat (100) @(negedge clk);
    strobe(1'b0, 3);
    wait_idle();
    // R5: request inside acquisition window is ignored
    cur_tag = "R5";
    strobe(1'b0, 3);
    repeat (20) @(negedge clk);
    check("R5", "no start in acquisition", int'(busy), 0);
    repeat (ACQ + 20) @(negedge clk);

    // R6: new result captured at completion, held afterwards
    cur_tag = "R6";
    result_in = 12'h6E2;
    strobe(1'b0, 3);
    wait_idle();
    result_in = 12'h111;
    repeat (10) @(negedge clk);
    strobe(1'b1, 6);
    @(negedge clk);
    @(negedge clk);
    check("R6", "held result top nibble", int'(data_out[11:8]), 'h6);
    repeat (10) @(negedge clk);

    check("R2", "conversion count", dut_rises, EXP_STARTS);
    finish_run();
  end

endmodule